// File: doc/BRIEF.md
# Masked Outbound Address Window Translator

This block rewrites outgoing bus addresses through a bank of programmable windows. Each window holds a match value, a remap value and a mask, all as wide as the address, plus a 32-bit action word that the downstream transaction builder reads to pick the transaction type and its attributes. A request address hits a window when it agrees with the window's match value in every bit position where the mask is one. On a hit, the masked bit positions of the address are replaced by the remap value, and the window's action word goes out with it. When no window hits, the address passes through unchanged and a separate default action word is used.

Software sets up the windows through a small register port with a write strobe, a word address and a combinational read path. Requests enter and leave through valid/ready handshakes with one register stage between them. The translation and the action are fixed when a request is accepted, so later register writes do not change a result that is waiting at the output. The action word's bit layout (type in bits 3:0, for example 0x0 memory, 0x4 I/O, 0x8 and 0x9 configuration, 0xC message, with attribute and function-number fields above) is defined for the consumer. This block stores it and forwards it without looking at it.

Top module: `owt_xlate`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every register reads as zero. This means all windows are disabled and the default action word is 0.
- R2: Register map, with byte address = window*0x20 + field offset. The field offsets are: match low 0x00, match high 0x04, remap low 0x08, remap high 0x0C, mask low 0x10, mask high 0x14, action 0x18. The default action word is at NWIN*0x20-4. Mask bits below GRAN_BITS (default 16) always read as zero. Other addresses read as zero and ignore writes, and so do addresses with bits 1:0 not zero.
- R3: Bit 0 of match low enables its window. An enabled window hits when ((addr ^ match) & mask) == 0. This makes the match bits below GRAN_BITS irrelevant.
- R4: On a hit, out_addr = (remap & mask) | (addr & ~mask). In particular, address bits below GRAN_BITS always pass through unchanged.
- R5: On a hit, out_action equals the hitting window's 32-bit action word, bit for bit.
- R6: When no window hits, out_addr equals the request address and out_action equals the default action word.
- R7: A window whose enable bit is 0 never hits, even if the address matches under its mask.
- R8: When several windows hit, the one with the lowest index sets the result.
- R9: A request accepted at a clock edge (in_valid and in_ready both 1) appears with out_valid 1 directly after that edge. With out_ready 1 and no new request, out_valid returns to 0 after the next edge.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_addr and out_action stay stable.
- R11: Register writes made while a result waits at the output do not change that result. A request accepted later uses the new register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register byte address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr (combinational) |
| in_valid | input | 1 | Request address valid |
| in_ready | output | 1 | Translator can accept a request |
| in_addr | input | ADDR_W | Untranslated request address |
| out_valid | output | 1 | Translated result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_addr | output | ADDR_W | Translated address |
| out_action | output | 32 | Action word of the hitting window, or the default word |

## Verification
The bench builds addresses that sit inside a window but have random low bits. A translator that compared bits outside the mask, or that remapped unmasked bits, would return the wrong address for these. Two windows are programmed to cover the same range. Getting R8 wrong would hand out the higher window's remap and action. A window is programmed to match but left disabled, and a design that ignored the enable bit would translate an address that should miss. The bench also holds a result under back-pressure while it rewrites the hitting window's registers. A design that re-evaluated the translation at the output stage would let the held address drift.

// File: rtl/owt_pkg.sv
package owt_pkg;
   // Field word index inside one window slot (byte offset / 4)
   typedef enum logic [2:0] {
      FLD_MATCH_LO = 3'd0,
      FLD_MATCH_HI = 3'd1,
      FLD_REMAP_LO = 3'd2,
      FLD_REMAP_HI = 3'd3,
      FLD_MASK_LO  = 3'd4,
      FLD_MASK_HI  = 3'd5,
      FLD_ACTION   = 3'd6,
      FLD_SPARE    = 3'd7
   } owt_field_e;

   localparam int unsigned SLOT_BYTES_LG2 = 5;   // 0x20 bytes per window
   localparam int unsigned CSR_DW         = 32;
   localparam int unsigned ACT_W          = 32;
endpackage

// File: rtl/owt_regfile.sv
module owt_regfile
   import owt_pkg::*;
#(
   parameter int unsigned NWIN      = 8,
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_BITS = 16,
   parameter int unsigned CSR_AW    = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             csr_we,
   input  logic [CSR_AW-1:0]                csr_addr,
   input  logic [CSR_DW-1:0]                csr_wdata,
   output logic [CSR_DW-1:0]                csr_rdata,
   output logic [NWIN-1:0][ADDR_W-1:0]      match_o,
   output logic [NWIN-1:0][ADDR_W-1:0]      remap_o,
   output logic [NWIN-1:0][ADDR_W-1:0]      mask_o,
   output logic [NWIN-1:0][ACT_W-1:0]       action_o,
   output logic [ACT_W-1:0]                 def_action_o
);
   localparam int unsigned HI_W   = ADDR_W - 32;
   localparam int unsigned WSEL_W = CSR_AW - SLOT_BYTES_LG2;
   localparam logic [CSR_AW-1:0] DEF_ADDR = CSR_AW'(NWIN * (1 << SLOT_BYTES_LG2) - 4);
   localparam logic [31:0] GRAN_KEEP = ~((32'h1 << GRAN_BITS) - 32'h1);

   logic [NWIN-1:0][ADDR_W-1:0] match_q, remap_q, mask_q;
   logic [NWIN-1:0][ACT_W-1:0]  action_q;
   logic [ACT_W-1:0]            def_q;

   logic              aligned;
   logic [WSEL_W-1:0] wsel;
   owt_field_e        fld;
   logic              is_def;

   assign aligned = (csr_addr[1:0] == 2'b00);
   assign wsel    = csr_addr[CSR_AW-1:SLOT_BYTES_LG2];
   assign fld     = owt_field_e'(csr_addr[SLOT_BYTES_LG2-1:2]);
   assign is_def  = aligned && (csr_addr == DEF_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q  <= '0;
         remap_q  <= '0;
         mask_q   <= '0;
         action_q <= '0;
         def_q    <= '0;
      end else if (csr_we && aligned) begin
         for (int w = 0; w < NWIN; w++) begin
            if (wsel == WSEL_W'(w)) begin
               case (fld)
                  FLD_MATCH_LO: match_q[w][31:0]       <= csr_wdata;
                  FLD_MATCH_HI: match_q[w][ADDR_W-1:32] <= csr_wdata[HI_W-1:0];
                  FLD_REMAP_LO: remap_q[w][31:0]       <= csr_wdata;
                  FLD_REMAP_HI: remap_q[w][ADDR_W-1:32] <= csr_wdata[HI_W-1:0];
                  FLD_MASK_LO:  mask_q[w][31:0]        <= csr_wdata & GRAN_KEEP;
                  FLD_MASK_HI:  mask_q[w][ADDR_W-1:32]  <= csr_wdata[HI_W-1:0];
                  FLD_ACTION:   action_q[w]            <= csr_wdata;
                  default: ;
               endcase
            end
         end
         if (is_def) def_q <= csr_wdata;
      end
   end

   always_comb begin
      csr_rdata = '0;
      if (aligned) begin
         for (int w = 0; w < NWIN; w++) begin
            if (wsel == WSEL_W'(w)) begin
               case (fld)
                  FLD_MATCH_LO: csr_rdata = match_q[w][31:0];
                  FLD_MATCH_HI: csr_rdata = CSR_DW'(match_q[w][ADDR_W-1:32]);
                  FLD_REMAP_LO: csr_rdata = remap_q[w][31:0];
                  FLD_REMAP_HI: csr_rdata = CSR_DW'(remap_q[w][ADDR_W-1:32]);
                  FLD_MASK_LO:  csr_rdata = mask_q[w][31:0];
                  FLD_MASK_HI:  csr_rdata = CSR_DW'(mask_q[w][ADDR_W-1:32]);
                  FLD_ACTION:   csr_rdata = action_q[w];
                  default:      csr_rdata = '0;
               endcase
            end
         end
         if (is_def) csr_rdata = def_q;
      end
   end

   assign match_o      = match_q;
   assign remap_o      = remap_q;
   assign mask_o       = mask_q;
   assign action_o     = action_q;
   assign def_action_o = def_q;
endmodule

// File: rtl/owt_match.sv
module owt_match
   import owt_pkg::*;
#(
   parameter int unsigned NWIN   = 8,
   parameter int unsigned ADDR_W = 64
) (
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [NWIN-1:0][ADDR_W-1:0]  match_i,
   input  logic [NWIN-1:0][ADDR_W-1:0]  remap_i,
   input  logic [NWIN-1:0][ADDR_W-1:0]  mask_i,
   input  logic [NWIN-1:0][ACT_W-1:0]   action_i,
   input  logic [ACT_W-1:0]             def_action_i,
   output logic [ADDR_W-1:0]            xaddr_o,
   output logic [ACT_W-1:0]             action_o
);
   logic [NWIN-1:0] hit;

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      assign hit[g] = match_i[g][0] & ~(|((addr_i ^ match_i[g]) & mask_i[g]));
   end

   // Scan from the top so the lowest-index hit is applied last
   always_comb begin
      xaddr_o  = addr_i;
      action_o = def_action_i;
      for (int w = NWIN - 1; w >= 0; w--) begin
         if (hit[w]) begin
            xaddr_o  = (remap_i[w] & mask_i[w]) | (addr_i & ~mask_i[w]);
            action_o = action_i[w];
         end
      end
   end
endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
   import owt_pkg::*;
#(
   parameter int unsigned NWIN      = 8,
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_BITS = 16,
   parameter int unsigned CSR_AW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [31:0]       out_action
);
   localparam int unsigned MIN_CSR_AW = $clog2(NWIN) + SLOT_BYTES_LG2;

   if (NWIN < 1) begin : g_chk_nwin
      $error("owt_xlate: NWIN must be at least 1");
   end
   if (ADDR_W <= 32 || ADDR_W > 64) begin : g_chk_aw
      $error("owt_xlate: ADDR_W must lie in 33..64");
   end
   if (GRAN_BITS < 1 || GRAN_BITS > 31) begin : g_chk_gran
      $error("owt_xlate: GRAN_BITS must lie in 1..31");
   end
   if (CSR_AW < MIN_CSR_AW || CSR_AW <= SLOT_BYTES_LG2) begin : g_chk_csr
      $error("owt_xlate: CSR_AW too narrow for NWIN windows");
   end

   logic [NWIN-1:0][ADDR_W-1:0] win_match, win_remap, win_mask;
   logic [NWIN-1:0][ACT_W-1:0]  win_action;
   logic [ACT_W-1:0]            def_action;
   logic [ADDR_W-1:0]           xaddr;
   logic [ACT_W-1:0]            xaction;

   owt_regfile #(
      .NWIN(NWIN), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .CSR_AW(CSR_AW)
   ) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .csr_we       (csr_we),
      .csr_addr     (csr_addr),
      .csr_wdata    (csr_wdata),
      .csr_rdata    (csr_rdata),
      .match_o      (win_match),
      .remap_o      (win_remap),
      .mask_o       (win_mask),
      .action_o     (win_action),
      .def_action_o (def_action)
   );

   owt_match #(
      .NWIN(NWIN), .ADDR_W(ADDR_W)
   ) i_match (
      .addr_i       (in_addr),
      .match_i      (win_match),
      .remap_i      (win_remap),
      .mask_i       (win_mask),
      .action_i     (win_action),
      .def_action_i (def_action),
      .xaddr_o      (xaddr),
      .action_o     (xaction)
   );

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_addr   <= '0;
         out_action <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_addr   <= xaddr;
            out_action <= xaction;
         end
      end
   end
endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk #(
   parameter int unsigned NWIN      = 8,
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_BITS = 16,
   parameter int unsigned CSR_AW    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CSR_AW-1:0] csr_addr,
   input logic [31:0]       csr_rdata,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] in_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic [31:0]       out_action
);
   logic mask_lo_sel;
   assign mask_lo_sel = (csr_addr[4:0] == 5'h10) && ((csr_addr >> 5) < NWIN);

   p_mask_gran_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_lo_sel |-> (csr_rdata[GRAN_BITS-1:0] == '0));

   p_low_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_addr[GRAN_BITS-1:0] == $past(in_addr[GRAN_BITS-1:0])));

   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

   p_stall_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_action)));
endmodule

bind owt_xlate owt_xlate_chk #(
   .NWIN(NWIN), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .CSR_AW(CSR_AW)
) i_owt_xlate_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .csr_addr   (csr_addr),
   .csr_rdata  (csr_rdata),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_addr    (in_addr),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_addr   (out_addr),
   .out_action (out_action)
);

// File: tb/test_owt_xlate.sv
module test_owt_xlate;
   localparam int NW = 8;
   localparam int AW = 64;
   localparam int CW = 8;
   localparam logic [CW-1:0] DEF_A = CW'(NW * 32 - 4);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csr_we = 1'b0;
   logic [CW-1:0] csr_addr = '0;
   logic [31:0]   csr_wdata = '0;
   logic [31:0]   csr_rdata;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [AW-1:0] in_addr = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [AW-1:0] out_addr;
   logic [31:0]   out_action;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [AW-1:0] m_match [NW];
   logic [AW-1:0] m_remap [NW];
   logic [AW-1:0] m_mask  [NW];
   logic [31:0]   m_act   [NW];
   logic [31:0]   m_def;

   always #4 clk = ~clk;

   owt_xlate #(.NWIN(NW), .ADDR_W(AW), .GRAN_BITS(16), .CSR_AW(CW)) i_owt_xlate (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .in_valid(in_valid),
      .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
      .out_ready(out_ready), .out_addr(out_addr), .out_action(out_action)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic csr_wr(input logic [CW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_we = 1'b1;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic csr_rd(input logic [CW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   // Program one field of one window and mirror it in the model
   task automatic win_wr(input int w, input int fld, input logic [31:0] d);
      logic [CW-1:0] a;
      a = CW'(w * 32 + fld * 4);
      case (fld)
         0: m_match[w][31:0]  = d;
         1: m_match[w][63:32] = d;
         2: m_remap[w][31:0]  = d;
         3: m_remap[w][63:32] = d;
         4: m_mask[w][31:0]   = d & 32'hFFFF_0000;
         5: m_mask[w][63:32]  = d;
         6: m_act[w]          = d;
         default: ;
      endcase
      csr_wr(a, d);
   endtask

   task automatic win_set(input int w, input logic [63:0] mt, input logic [63:0] rm,
                          input logic [63:0] mk, input logic [31:0] ac);
      win_wr(w, 0, mt[31:0]); win_wr(w, 1, mt[63:32]);
      win_wr(w, 2, rm[31:0]); win_wr(w, 3, rm[63:32]);
      win_wr(w, 4, mk[31:0]); win_wr(w, 5, mk[63:32]);
      win_wr(w, 6, ac);
   endtask

   function automatic void model(input logic [63:0] a, output logic [63:0] ea,
                                 output logic [31:0] eact);
      ea = a; eact = m_def;
      for (int w = NW - 1; w >= 0; w--) begin
         if (m_match[w][0] && (((a ^ m_match[w]) & m_mask[w]) == 64'h0)) begin
            ea   = (m_remap[w] & m_mask[w]) | (a & ~m_mask[w]);
            eact = m_act[w];
         end
      end
   endfunction

   // One request with the consumer ready; result is checked right after acceptance
   task automatic xfer(input logic [63:0] a, input string req);
      logic [63:0] ea;
      logic [31:0] eact;
      model(a, ea, eact);
      @(negedge clk);
      out_ready = 1'b1; in_addr = a; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " R9 out_valid"}, 64'(out_valid), 64'h1);
      check({req, " addr"}, out_addr, ea);
      check({req, " action"}, 64'(out_action), 64'(eact));
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] rd;
      logic [63:0] mk, mt, a, hold_a;
      logic [31:0] hold_act;
      int k;
      void'($urandom(32'd20240611));
      for (int w = 0; w < NW; w++) begin
         m_match[w] = '0; m_remap[w] = '0; m_mask[w] = '0; m_act[w] = '0;
      end
      m_def = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1;
      check("R1 out_valid", 64'(out_valid), 64'h0);
      check("R1 in_ready", 64'(in_ready), 64'h1);
      csr_rd(8'h00, rd); check("R1 match lo w0", 64'(rd), 64'h0);
      csr_rd(8'hF8, rd); check("R1 action w7", 64'(rd), 64'h0);
      csr_rd(DEF_A, rd); check("R1 default action", 64'(rd), 64'h0);
      xfer(64'h1234_5678_9ABC_DEF0, "R1 R6 reset miss");

      // R2: readback, granule mask clear, unmapped slot, misaligned write
      win_wr(3, 4, 32'hFFFF_FFFF);
      csr_rd(8'h70, rd); check("R2 mask lo granule", 64'(rd), 64'hFFFF_0000);
      win_wr(3, 1, 32'hCAFE_0001);
      csr_rd(8'h64, rd); check("R2 match hi w3", 64'(rd), 64'hCAFE_0001);
      csr_wr(8'h1C, 32'hDEAD_BEEF);
      csr_rd(8'h1C, rd); check("R2 spare slot", 64'(rd), 64'h0);
      csr_wr(8'h19, 32'h5555_5555);
      csr_rd(8'h18, rd); check("R2 misaligned write ignored", 64'(rd), 64'h0);
      csr_wr(DEF_A, 32'h0000_00C0); m_def = 32'h0000_00C0;
      csr_rd(DEF_A, rd); check("R2 default readback", 64'(rd), 64'hC0);
      win_set(3, 64'h0, 64'h0, 64'h0, 32'h0);

      // R6: miss uses default action
      xfer(64'h0000_0042_0001_0000, "R6 miss default");

      // R3 R4 R5: hit with low match bits set (ignored), 1 MiB window
      win_set(1, 64'h0000_0010_0030_ABCD, 64'h0000_00F0_0050_0000,
              64'hFFFF_FFFF_FFF0_0000, 32'h00A4_0C94);
      xfer(64'h0000_0010_003E_1234, "R3 R4 R5 hit");
      xfer(64'h0000_0010_0040_0000, "R3 just outside");

      // R7: matching but disabled window
      win_set(4, 64'h0000_0077_0000_0000, 64'h0000_0011_0000_0000,
              64'hFFFF_FFFF_0000_0000, 32'h9);
      win_wr(4, 0, 32'h0);
      xfer(64'h0000_0077_1234_5678, "R7 disabled");
      check("R7 addr untouched", out_addr, 64'h0000_0077_1234_5678);

      // R8: overlap, window 2 beats window 5
      win_set(5, 64'h0000_0200_0000_0001, 64'h0000_0500_0000_0000,
              64'hFFFF_FF00_0000_0000, 32'h0000_0004);
      win_set(2, 64'h0000_0200_0000_0001, 64'h0000_0300_0000_0000,
              64'hFFFF_FFF0_0000_0000, 32'h0000_0008);
      xfer(64'h0000_0200_0ABC_DEF0, "R8 priority");
      check("R8 action from lower window", 64'(out_action), 64'h8);

      // R10 R11: stall, rewrite the hitting window, result must hold
      model(64'h0000_0200_0000_1000, hold_a, hold_act);
      @(negedge clk);
      out_ready = 1'b0; in_addr = 64'h0000_0200_0000_1000; in_valid = 1'b1;
      @(negedge clk);
      in_addr = 64'h0000_0200_0000_2000;
      check("R10 in_ready low", 64'(in_ready), 64'h0);
      win_wr(2, 2, 32'h0);
      win_wr(2, 3, 32'h0000_0999);
      win_wr(2, 6, 32'h0000_000C);
      check("R11 held addr", out_addr, hold_a);
      check("R11 held action", 64'(out_action), 64'(hold_act));
      check("R10 still valid", 64'(out_valid), 64'h1);
      model(64'h0000_0200_0000_2000, hold_a, hold_act);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 new config addr", out_addr, hold_a);
      check("R11 new config action", 64'(out_action), 64'(hold_act));
      @(negedge clk);
      check("R9 drained", 64'(out_valid), 64'h0);

      // Random windows and traffic
      for (int it = 0; it < 6; it++) begin
         for (int w = 0; w < NW; w++) begin
            k  = 16 + $urandom_range(0, 24);
            mk = ~64'h0 << k;
            mt = rnd64();
            mt[0] = ($urandom_range(0, 3) != 0);
            win_set(w, mt, rnd64(), mk, $urandom);
         end
         csr_wr(DEF_A, 32'h0000_0A00 + 32'(it)); m_def = 32'h0000_0A00 + 32'(it);
         for (int n = 0; n < 30; n++) begin
            k = $urandom_range(0, NW - 1);
            if ($urandom_range(0, 2) != 0) a = (m_match[k] & m_mask[k]) | (rnd64() & ~m_mask[k]);
            else a = rnd64();
            xfer(a, "R3 R4 R5 R6 R8 random");
         end
      end

      summary();
   end
endmodule